// File: doc/BRIEF.md
# Telecom Bus Transmit Frame Aligner

This block drives the transmit side of a byte-wide SONET telecom bus. An external frame-sync pulse, one byte clock wide and repeating every 125 us, marks the frame timing; the block waits a programmable number of byte clocks after the rising edge of that pulse and then presents the first byte of a new frame. From then on a byte-position counter runs freely, wrapping at the frame length, and marks every first byte with a start-of-frame flag.

The bus runs either as a single STS-1 stream or as three byte-interleaved STS-1 streams forming an STS-3. In the interleaved case, only one of the three time slots belongs to this block. Local payload bytes are pulled through a ready signal only in owned bytes. The foreign slots are either driven as zero bytes or released through the output-enable, so that up to three devices can share one bus. When the interface is disabled, the block holds its outputs idle and waits for a fresh sync edge.

Top module: `tbus_tx_aligner`

## Requirements
- R1: After reset, and before the first alignment completes, bus_oe, bus_sof, bus_slot_vld and pay_ready are 0 and bus_data is 0x00.
- R2: The delay is the 16-bit value {dly_hi, dly_lo}. A sync rising edge is a clock edge where fsync is 1 and was 0 at the previous edge. With delay 0, the first frame byte (bus_sof=1) is presented right after that edge.
- R3: With delay N>0, the first frame byte is presented right after the N-th clock edge following the edge that detected the sync rising edge.
- R4: A sync rising edge during a running countdown restarts the countdown from the new edge with the current delay value.
- R5: Once aligned, and without new sync edges, bus_sof repeats every ROWS*COLS bytes when sts1_mode=1 and every 3*ROWS*COLS bytes when sts1_mode=0.
- R6: With sts1_mode=0, the time slot of frame byte p is p mod 3. A byte is owned when its slot equals slot_sel. slot_sel=3 owns no byte.
- R7: In an owned byte, bus_slot_vld=1, pay_ready=1, bus_oe=1 and bus_data equals pay_data.
- R8: With frac_en=0, a non-owned byte of an aligned frame is driven as 0x00 with bus_oe=1.
- R9: With frac_en=1, a non-owned byte has bus_oe=0 and bus_data=0x00.
- R10: With sts1_mode=1, every byte of an aligned frame is owned, whatever slot_sel holds.
- R11: An edge with en=0 drops alignment and cancels any countdown, so that R1 outputs follow. Sync edges are ignored while en=0. After en returns, the block stays idle until a new sync rising edge.
- R12: A sync rising edge while aligned realigns the byte position to 0 after the programmed delay. Until then, the old frame keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Telecom bus interface enable |
| sts1_mode | input | 1 | 1 = single STS-1, 0 = three-way interleaved STS-3 |
| frac_en | input | 1 | 1 = release the bus in foreign slots, 0 = drive zeros there |
| slot_sel | input | 2 | Owned STS-3 time slot (0..2, 3 = none) |
| dly_lo | input | 8 | Lower byte of the sync-to-first-byte delay |
| dly_hi | input | DLY_W-8 | Upper part of the sync-to-first-byte delay |
| fsync | input | 1 | 8 kHz frame-sync pulse |
| pay_data | input | 8 | Local payload byte, valid while pay_ready is high |
| pay_ready | output | 1 | Payload byte consumed in this cycle |
| bus_data | output | 8 | Bus data byte |
| bus_oe | output | 1 | Output enable for the bus tri-state driver |
| bus_sof | output | 1 | First byte of the frame |
| bus_slot_vld | output | 1 | Current byte belongs to this block |

## Verification
The bench builds the block with ROWS=2 and COLS=5, so an STS-1 frame is 10 bytes and an STS-3 frame is 30. This brings many frame wraps, slot rotations and mode changes within a few hundred cycles. DLY_W stays at 16, so a delay of 259 exercises the upper delay byte within the same run. A behavioural model in the bench predicts every output on every clock across all three slot selections, the unowned selection, both fill modes and disable/re-enable.

// File: rtl/tbus_tx_aligner.sv
module tbus_tx_aligner #(
  parameter int ROWS  = 9,
  parameter int COLS  = 90,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sts1_mode,
  input  logic             frac_en,
  input  logic [1:0]       slot_sel,
  input  logic [7:0]       dly_lo,
  input  logic [DLY_W-9:0] dly_hi,
  input  logic             fsync,
  input  logic [7:0]       pay_data,
  output logic             pay_ready,
  output logic [7:0]       bus_data,
  output logic             bus_oe,
  output logic             bus_sof,
  output logic             bus_slot_vld
);
  localparam int STS1_LEN = ROWS * COLS;
  localparam int STS3_LEN = 3 * STS1_LEN;
  localparam int PW       = $clog2(STS3_LEN);

  logic             fs_q, armed, aligned;
  logic [DLY_W-1:0] cnt;
  logic [PW-1:0]    pos;
  logic [1:0]       slot;

  wire [DLY_W-1:0] dly    = {dly_hi, dly_lo};
  wire             rise   = en & fsync & ~fs_q;
  wire             expire = armed & ~rise & (cnt == DLY_W'(1));
  wire             start  = (rise & (dly == '0)) | expire;
  wire [PW-1:0]    last   = sts1_mode ? PW'(STS1_LEN - 1) : PW'(STS3_LEN - 1);
  wire             own    = aligned & (sts1_mode | (slot == slot_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      armed   <= 1'b0;
      aligned <= 1'b0;
      cnt     <= '0;
      pos     <= '0;
      slot    <= '0;
    end else begin
      fs_q <= fsync;
      if (!en) begin
        armed   <= 1'b0;
        aligned <= 1'b0;
        cnt     <= '0;
        pos     <= '0;
        slot    <= '0;
      end else begin
        if (rise) begin
          armed <= (dly != '0);
          cnt   <= dly;
        end else if (armed) begin
          cnt <= cnt - 1'b1;
          if (cnt == DLY_W'(1)) armed <= 1'b0;
        end
        if (start) begin
          aligned <= 1'b1;
          pos     <= '0;
          slot    <= '0;
        end else if (aligned) begin
          if (pos >= last) begin
            pos  <= '0;
            slot <= '0;
          end else begin
            pos  <= pos + 1'b1;
            slot <= (slot == 2'd2) ? 2'd0 : slot + 1'b1;
          end
        end
      end
    end
  end

  assign bus_slot_vld = own;
  assign pay_ready    = own;
  assign bus_data     = own ? pay_data : 8'h00;
  assign bus_oe       = aligned & (own | ~frac_en);
  assign bus_sof      = aligned & (pos == '0);
endmodule

// File: rtl/tbus_tx_aligner_chk.sv
module tbus_tx_aligner_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sts1_mode,
  input logic             frac_en,
  input logic [7:0]       dly_lo,
  input logic [DLY_W-9:0] dly_hi,
  input logic             fsync,
  input logic [7:0]       pay_data,
  input logic             pay_ready,
  input logic [7:0]       bus_data,
  input logic             bus_oe,
  input logic             bus_sof,
  input logic             bus_slot_vld
);
  logic fs_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fs_prev <= 1'b0;
    else        fs_prev <= fsync;

  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bus_oe && !bus_sof && !bus_slot_vld && bus_data == 8'h00));

  p_zero_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fsync && !fs_prev && {dly_hi, dly_lo} == '0) |=> bus_sof);

  p_own_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_slot_vld |-> (bus_oe && pay_ready && bus_data == pay_data));

  p_foreign_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !bus_slot_vld) |-> (bus_data == 8'h00 && !frac_en));

  p_frac_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_en && !bus_slot_vld) |-> !bus_oe);

  p_sts1_all_own_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts1_mode && bus_oe) |-> bus_slot_vld);
endmodule

bind tbus_tx_aligner tbus_tx_aligner_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sts1_mode(sts1_mode), .frac_en(frac_en),
  .dly_lo(dly_lo), .dly_hi(dly_hi), .fsync(fsync), .pay_data(pay_data),
  .pay_ready(pay_ready), .bus_data(bus_data), .bus_oe(bus_oe),
  .bus_sof(bus_sof), .bus_slot_vld(bus_slot_vld)
);

// File: tb/test_tbus_tx_aligner.sv
`timescale 1ns/1ps
module test_tbus_tx_aligner;
  localparam int ROWS = 2, COLS = 5, DLY_W = 16;
  localparam int L1 = ROWS * COLS;

  logic clk = 0, rst_n = 0, en = 0, sts1_mode = 1, frac_en = 0, fsync = 0;
  logic [1:0] slot_sel = 0;
  logic [7:0] dly_lo = 0, dly_hi = 0, pay_data = 8'h5a;
  logic pay_ready, bus_oe, bus_sof, bus_slot_vld;
  logic [7:0] bus_data;

  int errors = 0, checks = 0;
  string tag = "R1";

  int m_fsq = 0, m_wait = -1, m_aligned = 0, m_pos = 0;

  always #2 clk = ~clk;

  tbus_tx_aligner #(.ROWS(ROWS), .COLS(COLS), .DLY_W(DLY_W)) i_tbus_tx_aligner (
    .clk(clk), .rst_n(rst_n), .en(en), .sts1_mode(sts1_mode), .frac_en(frac_en),
    .slot_sel(slot_sel), .dly_lo(dly_lo), .dly_hi(dly_hi), .fsync(fsync),
    .pay_data(pay_data), .pay_ready(pay_ready), .bus_data(bus_data),
    .bus_oe(bus_oe), .bus_sof(bus_sof), .bus_slot_vld(bus_slot_vld));

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int len, own, oe, start;
    if (!rst_n) begin
      m_fsq = 0; m_wait = -1; m_aligned = 0; m_pos = 0;
    end else begin
      if (!en) begin
        m_wait = -1; m_aligned = 0; m_pos = 0;
      end else begin
        len = sts1_mode ? L1 : 3 * L1;
        start = 0;
        if (fsync && !m_fsq) m_wait = {dly_hi, dly_lo};
        else if (m_wait > 0) m_wait--;
        if (m_wait == 0) begin start = 1; m_wait = -1; end
        if (start) begin m_aligned = 1; m_pos = 0; end
        else if (m_aligned) m_pos = (m_pos + 1 >= len) ? 0 : m_pos + 1;
      end
      m_fsq = fsync;
    end
    #1;
    own = m_aligned && (sts1_mode || (m_pos % 3) == slot_sel);
    oe  = m_aligned && (own || !frac_en);
    check(tag, {bus_oe, bus_sof, bus_slot_vld, pay_ready, bus_data},
          {oe[0], (m_aligned != 0 && m_pos == 0), own[0], own[0],
           own ? pay_data : 8'h00});
  end

  always @(negedge clk) pay_data <= pay_data * 8'd5 + 8'd3;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse;
    @(negedge clk) fsync = 1;
    @(negedge clk) fsync = 0;
  endtask

  task automatic sof_after_sync(string req, int exp);
    int n = 0;
    @(negedge clk) fsync = 1;
    @(posedge clk); #1;
    while (!bus_sof && n < 2000) begin
      @(negedge clk) fsync = 0;
      @(posedge clk); #1;
      n++;
    end
    @(negedge clk) fsync = 0;
    check(req, 12'(n), 12'(exp));
  endtask

  task automatic sof_gap(string req, int exp);
    int n = 0;
    @(posedge clk); #1;
    while (!bus_sof && n < 2000) begin @(posedge clk); #1; end
    @(posedge clk); #1; n = 1;
    while (!bus_sof && n < 2000) begin @(posedge clk); #1; n++; end
    check(req, 12'(n), 12'(exp));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    tag = "R1"; en = 1; cyc(20);
    tag = "R2"; sof_after_sync("R2", 0); cyc(25);
    tag = "R5"; sof_gap("R5", L1);
    en = 0; cyc(2); en = 1;
    tag = "R3"; dly_hi = 8'h01; dly_lo = 8'h03; sof_after_sync("R3", 259); cyc(5);
    en = 0; cyc(2); en = 1;
    tag = "R4"; dly_hi = 0; dly_lo = 7; pulse(); cyc(2);
    sof_after_sync("R4", 7); cyc(4);
    tag = "R6"; sts1_mode = 0; frac_en = 0; slot_sel = 1; dly_lo = 0;
    pulse(); cyc(40);
    tag = "R5"; sof_gap("R5", 3 * L1);
    tag = "R8"; slot_sel = 0; cyc(35);
    tag = "R9"; frac_en = 1; slot_sel = 2; cyc(35);
    slot_sel = 0; cyc(35);
    tag = "R6"; slot_sel = 3; cyc(35);
    tag = "R7"; slot_sel = 1; frac_en = 0; cyc(35);
    tag = "R10"; sts1_mode = 1; frac_en = 1; slot_sel = 2; cyc(25);
    tag = "R11"; dly_lo = 4; pulse(); en = 0; cyc(3);
    en = 1; cyc(20);
    pulse(); cyc(15);
    tag = "R12"; cyc(3); dly_lo = 2; pulse(); cyc(25);
    sts1_mode = 0; frac_en = 0; slot_sel = 2; cyc(12);
    dly_lo = 0; pulse(); cyc(40);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule